// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block keeps a handful of recent page-to-frame mappings in registers. Every entry is compared against the page number of a request in the same cycle. On a hit, the physical address is formed by placing the stored frame number above the untouched page offset. No page-table read is needed. On a miss, the block reports that the mapping is absent. The requester then fetches the mapping from the page table in memory and writes it back through the fill port.

Each entry holds a valid flag and a read-only flag. A write request that hits a read-only page is answered as a hit with a protection fault. A single flush pulse empties the cache, for example when the running process changes. Two saturating counters record hits and misses so that the hit ratio can be measured.

The request is sampled on one rising edge and the registered response appears on the next. A fill or flush issued in the same cycle as a request does not change that request's answer.

Top module: `xlate_cache`

## Requirements
- R1: A request with `lk_valid` high is answered one cycle later with `rsp_valid` high. `rsp_hit` is high exactly when some valid entry holds a page number equal to the upper `VPN_W` bits of `lk_vaddr`.
- R2: On a hit, `rsp_paddr` is the matching entry's frame number in the upper `PFN_W` bits, concatenated with the request's low `OFF_W` offset bits unchanged.
- R3: On a miss, `rsp_hit`, `rsp_ro` and `rsp_fault` are 0 and `rsp_paddr` is 0.
- R4: After reset, every entry is invalid, all response outputs are 0, both counters are 0, and the replacement pointer is at entry 0.
- R5: On a hit, `rsp_ro` returns the entry's read-only flag. `rsp_fault` is 1 only when `lk_write` is 1 and the hit entry is read-only. Reads never fault, and writes to writable pages never fault.
- R6: While any entry is invalid, a fill writes the lowest-numbered invalid entry and leaves the replacement pointer unchanged.
- R7: When all entries are valid, a fill overwrites the entry selected by the replacement pointer. The pointer then advances by one and wraps from `ENTRIES-1` to 0.
- R8: A flush pulse clears every valid flag at one clock edge. If a fill arrives in the same cycle as a flush, the fill is dropped.
- R9: If several valid entries hold the requested page number, the lowest-numbered one supplies the frame number and read-only flag.
- R10: `hit_count` and `miss_count` each rise by one for every hit or miss response, hold their value when no request is made, and saturate at their all-ones value.
- R11: In a cycle following no request, `rsp_valid`, `rsp_hit` and `rsp_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Translation request strobe |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address: page number above offset |
| lk_write | input | 1 | Request is a store |
| flush | input | 1 | Invalidate all entries |
| fill_en | input | 1 | Write a new mapping |
| fill_vpn | input | VPN_W | Page number of the new mapping |
| fill_pfn | input | PFN_W | Frame number of the new mapping |
| fill_ro | input | 1 | New mapping is read-only |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Mapping found |
| rsp_paddr | output | PFN_W+OFF_W | Physical address on hit, else 0 |
| rsp_ro | output | 1 | Read-only flag of the hit entry |
| rsp_fault | output | 1 | Store to a read-only page |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
The bench builds the block with four entries, an 8-bit page number, a 6-bit frame number, a 4-bit offset and 3-bit counters. Four entries let a few fills fill the cache completely, so the bench can drive the replacement pointer through several evictions. It can also tell lowest-free placement apart from pointer placement. The 3-bit counters saturate at 7 after a short run of requests, so the holding behaviour at the top of the count range is checked directly.

// File: rtl/xc_pkg.sv
package xc_pkg;
  // Storage update selected for the current cycle; flush outranks fill.
  typedef enum logic [1:0] {
    XC_IDLE  = 2'd0,
    XC_FLUSH = 2'd1,
    XC_FILL  = 2'd2
  } xc_op_e;
endpackage

// File: rtl/xc_match.sv
module xc_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]              key,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx
);
  logic [ENTRIES-1:0] eq;

  // One comparator per entry, all working in parallel.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = valid[g] && (tags[g] == key);
  end

  assign hit = |eq;

  // The scan runs from high to low, so the lowest matching index is written last and wins.
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid,
  input  logic               fill_go,
  output logic [IDX_W-1:0]   victim
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic             all_full;

  assign all_full = &valid;

  // Lowest-numbered invalid entry.
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim = all_full ? rr_ptr : free_idx;

  // The pointer moves only when a fill actually evicts an entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (fill_go && all_full) begin
      rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/xc_sat_cnt.sv
module xc_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && !(&count)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 16,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_ro,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_ro,
  output logic             rsp_fault,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  import xc_pkg::*;

  // Entry storage. Only the valid flags are reset; the data fields need no reset.
  logic [ENTRIES-1:0]            ent_v;
  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
  logic [ENTRIES-1:0][PFN_W-1:0] ent_pfn;
  logic [ENTRIES-1:0]            ent_ro;

  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  logic             cam_hit;
  logic [IDX_W-1:0] cam_idx;
  logic [IDX_W-1:0] vic_idx;
  logic             lk_hit;
  logic             lk_miss;
  xc_op_e           op;

  assign req_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign req_off = lk_vaddr[OFF_W-1:0];
  assign lk_hit  = lk_valid && cam_hit;
  assign lk_miss = lk_valid && !cam_hit;

  always_comb begin
    if (flush)        op = XC_FLUSH;
    else if (fill_en) op = XC_FILL;
    else              op = XC_IDLE;
  end

  xc_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .valid (ent_v),
    .tags  (ent_vpn),
    .key   (req_vpn),
    .hit   (cam_hit),
    .idx   (cam_idx)
  );

  xc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .valid   (ent_v),
    .fill_go (op == XC_FILL),
    .victim  (vic_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
    end else begin
      case (op)
        XC_FLUSH: ent_v <= '0;
        XC_FILL:  ent_v[vic_idx] <= 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (op == XC_FILL) begin
      ent_vpn[vic_idx] <= fill_vpn;
      ent_pfn[vic_idx] <= fill_pfn;
      ent_ro[vic_idx]  <= fill_ro;
    end
  end

  // Registered response stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_ro    <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      rsp_paddr <= lk_hit ? {ent_pfn[cam_idx], req_off} : '0;
      rsp_ro    <= lk_hit && ent_ro[cam_idx];
      rsp_fault <= lk_hit && lk_write && ent_ro[cam_idx];
    end
  end

  xc_sat_cnt #(.W(CNT_W)) u_hits (
    .clk   (clk),
    .rst   (rst),
    .inc   (lk_hit),
    .count (hit_count)
  );

  xc_sat_cnt #(.W(CNT_W)) u_misses (
    .clk   (clk),
    .rst   (rst),
    .inc   (lk_miss),
    .count (miss_count)
  );
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int PA_W  = 28,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             flush,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_ro,
  input logic             rsp_fault,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst) lk_valid |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst) !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault)); // R11
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst) (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && !rsp_ro && !rsp_fault)); // R3
  AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (rst) rsp_fault |-> (rsp_hit && rsp_ro)); // R5
  AST_EMPTY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst) flush |=> (lk_valid |=> !rsp_hit)); // R8
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst) !lk_valid |=> ($stable(hit_count) && $stable(miss_count))); // R10
  AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (rst) (hit_count >= $past(hit_count)) && (miss_count >= $past(miss_count))); // R10
endmodule

bind xlate_cache xlate_cache_chk #(.PA_W(PFN_W + OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .flush      (flush),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_paddr  (rsp_paddr),
  .rsp_ro     (rsp_ro),
  .rsp_fault  (rsp_fault),
  .hit_count  (hit_count),
  .miss_count (miss_count)
);

// File: tb/xlate_cache_test.sv
`timescale 1ns/1ps
module xlate_cache_test;
  localparam int VPN_W = 8;
  localparam int PFN_W = 6;
  localparam int OFF_W = 4;
  localparam int ENT   = 4;
  localparam int CNT_W = 3;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lk_valid = 1'b0;
  logic [VA_W-1:0]  lk_vaddr = '0;
  logic             lk_write = 1'b0;
  logic             flush = 1'b0;
  logic             fill_en = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic             fill_ro = 1'b0;
  logic             rsp_valid, rsp_hit, rsp_ro, rsp_fault;
  logic [PA_W-1:0]  rsp_paddr;
  logic [CNT_W-1:0] hit_count, miss_count;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_hits = 0;
  int exp_miss = 0;

  always #4 clk = ~clk;

  xlate_cache #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .ENTRIES(ENT), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
    .flush(flush), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_ro(fill_ro),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_ro(rsp_ro),
    .rsp_fault(rsp_fault), .hit_count(hit_count), .miss_count(miss_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill(input int vpn, input int pfn, input bit ro);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = VPN_W'(vpn); fill_pfn = PFN_W'(pfn); fill_ro = ro;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_flush(input bit with_fill, input int vpn);
    @(negedge clk);
    flush = 1'b1;
    fill_en = with_fill; fill_vpn = VPN_W'(vpn); fill_pfn = '0; fill_ro = 1'b0;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
  endtask

  // One request; expected answer worked out from the requirements.
  task automatic look(input string req, input int vpn, input int off, input bit wr,
                      input bit ehit, input int epfn, input bit ero);
    int epa;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {VPN_W'(vpn), OFF_W'(off)}; lk_write = wr;
    @(negedge clk);
    lk_valid = 1'b0; lk_write = 1'b0;
    if (ehit) begin
      if (exp_hits < CMAX) exp_hits++;
    end else begin
      if (exp_miss < CMAX) exp_miss++;
    end
    epa = ehit ? ((epfn << OFF_W) | off) : 0;
    chk({req, " R1 rsp_valid"}, int'(rsp_valid), 1);
    chk({req, " R1 rsp_hit"}, int'(rsp_hit), int'(ehit));
    chk({req, " R2 rsp_paddr"}, int'(rsp_paddr), epa);
    chk({req, " R5 rsp_ro"}, int'(rsp_ro), int'(ehit && ero));
    chk({req, " R5 rsp_fault"}, int'(rsp_fault), int'(ehit && ero && wr));
    chk({req, " R10 hit_count"}, int'(hit_count), exp_hits);
    chk({req, " R10 miss_count"}, int'(miss_count), exp_miss);
  endtask

  task automatic t_reset();
    chk("R4 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R4 rsp_hit after reset", int'(rsp_hit), 0);
    chk("R4 rsp_paddr after reset", int'(rsp_paddr), 0);
    chk("R4 hit_count after reset", int'(hit_count), 0);
    chk("R4 miss_count after reset", int'(miss_count), 0);
    look("R4 R3 empty cache", 'h11, 0, 0, 0, 0, 0);
  endtask

  task automatic t_basic();
    fill('h11, 'h05, 0);
    look("R1 R2 read hit", 'h11, 'hA, 0, 1, 'h05, 0);
    look("R2 write hit offset", 'h11, 'h3, 1, 1, 'h05, 0);
    look("R3 neighbour page", 'h12, 'h3, 0, 0, 0, 0);
  endtask

  task automatic t_protect();
    fill('h22, 'h07, 1);
    look("R5 read of ro page", 'h22, 5, 0, 1, 'h07, 1);
    look("R5 write of ro page", 'h22, 5, 1, 1, 'h07, 1);
    look("R5 write of rw page", 'h11, 0, 1, 1, 'h05, 0);
  endtask

  task automatic t_round_robin();
    do_flush(0, 0);
    fill('h31, 1, 0); fill('h32, 2, 0); fill('h33, 3, 0); fill('h34, 4, 0);
    fill('h35, 5, 0);  // full: pointer at 0 evicts page 31
    look("R7 evicted 0", 'h31, 0, 0, 0, 0, 0);
    look("R7 kept 1", 'h32, 1, 0, 1, 2, 0);
    look("R7 new in 0", 'h35, 2, 0, 1, 5, 0);
    fill('h36, 6, 0);  // pointer at 1 evicts page 32
    look("R7 evicted 1", 'h32, 0, 0, 0, 0, 0);
    look("R7 kept 2", 'h33, 0, 0, 1, 3, 0);
    look("R7 new in 1", 'h36, 0, 0, 1, 6, 0);
  endtask

  task automatic t_free_first();
    do_flush(0, 0);  // pointer stays at 2
    fill('h41, 9, 0); fill('h42, 10, 0); fill('h43, 11, 0); fill('h44, 12, 0);
    fill('h45, 13, 0);  // pointer at 2 evicts page 43
    look("R6 lowest free 0", 'h41, 0, 0, 1, 9, 0);
    look("R6 lowest free 1", 'h42, 0, 0, 1, 10, 0);
    look("R6 R7 evicted 2", 'h43, 0, 0, 0, 0, 0);
    look("R6 lowest free 3", 'h44, 0, 0, 1, 12, 0);
    look("R7 new in 2", 'h45, 0, 0, 1, 13, 0);
  endtask

  task automatic t_flush();
    do_flush(0, 0);
    look("R8 flushed a", 'h41, 0, 0, 0, 0, 0);
    look("R8 flushed b", 'h45, 0, 0, 0, 0, 0);
    do_flush(1, 'h50);
    look("R8 fill dropped by flush", 'h50, 0, 0, 0, 0, 0);
  endtask

  task automatic t_duplicate();
    fill('h60, 20, 1);  // entry 0
    fill('h60, 21, 0);  // entry 1
    look("R9 lowest index wins", 'h60, 7, 1, 1, 20, 1);
  endtask

  task automatic t_idle();
    repeat (3) @(negedge clk);
    chk("R11 rsp_valid idle", int'(rsp_valid), 0);
    chk("R11 rsp_hit idle", int'(rsp_hit), 0);
    chk("R10 hit_count idle", int'(hit_count), exp_hits);
    chk("R10 miss_count idle", int'(miss_count), exp_miss);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 10; i++) look("R10 hit run", 'h60, i, 0, 1, 20, 1);
    for (int i = 0; i < 10; i++) look("R10 miss run", 'h77, i, 0, 0, 0, 0);
    chk("R10 hit_count saturated", int'(hit_count), CMAX);
    chk("R10 miss_count saturated", int'(miss_count), CMAX);
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_protect();
    t_round_robin();
    t_free_first();
    t_flush();
    t_duplicate();
    t_idle();
    t_saturate();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule